// File: doc/BRIEF.md
# Miss Status Holding Register File

This block keeps track of the read misses a single cache bank is waiting on. Each read that enters the tag-lookup stage claims an entry straight away and carries the returned id down the pipeline. One stage later the bank knows whether the read hit. A hit hands the entry back through the release port. A miss keeps the entry, which stores the line address and the per-port request metadata until memory answers.

In the same cycle as the allocation, a lookup compares the request's line address with every entry still waiting. A match means a fetch for that line is already in flight, so the bank merges the miss and issues no second memory request. When a memory response arrives, its id selects an entry. That entry's line address is returned, and every entry waiting on that line becomes ready. Ready entries then leave through a valid/ready dequeue port, oldest allocation first, so the bank can replay them.

A separate occupancy counter counts accepted reads and drops on every dequeue and release. It raises an almost-full flag early enough for the bank to stop taking new core requests before the entries run out.

Top module: `mshr_file`

## Requirements
- R1: `alloc_ready` is high exactly when some entry is free, and `alloc_id` combinationally shows the lowest-numbered free entry. An allocation (`alloc_valid` with `alloc_ready`) makes that entry valid and not ready from the next cycle. An id that is still valid is never handed out.
- R2: Entries are created only by `alloc_valid`. A lookup with `lookup_replay` high reports `lookup_match` low and creates no entry.
- R3: For a normal lookup, `lookup_match` is high in the same cycle exactly when some valid, not-yet-ready entry holds a line address equal to `lookup_addr`.
- R4: While `fill_valid` is high, `fill_addr` combinationally shows the line address stored in entry `fill_id`. From the next cycle, every valid entry holding that address is ready.
- R5: `deq_valid` is high when any entry is ready. `deq_id`, `deq_addr` and the metadata outputs then show the ready entry that was allocated earliest, with the metadata exactly as given at allocation. The metadata concatenation is {wsel, ctag, tid, pmask}. When `deq_ready` is also high, that entry is free from the next cycle.
- R6: `release_valid` frees entry `release_id` from the next cycle. The freed id can then be allocated again under the lowest-free rule.
- R7: An internal count rises by one on each `req_accept` and falls by one for each dequeue handshake and each release in a cycle. `almost_full` is high while the count is at least ENTRIES minus AF_MARGIN (3 with the defaults).
- R8: After reset, no entry is valid or ready: `alloc_ready`=1, `alloc_id`=0, `deq_valid`=0, `lookup_match`=0, `almost_full`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| alloc_valid | input | 1 | Claim an entry for a read entering lookup |
| alloc_addr | input | LINE_W | Line address of the read |
| alloc_wsel | input | PORTS*WSEL_W | Per-port word select |
| alloc_ctag | input | PORTS*CTAG_W | Per-port core tag |
| alloc_tid | input | PORTS*TID_W | Per-port thread id |
| alloc_pmask | input | PORTS | Port-valid mask |
| alloc_ready | output | 1 | A free entry exists |
| alloc_id | output | IDW | Id granted to the allocation |
| lookup_valid | input | 1 | Compare a line against waiting entries |
| lookup_replay | input | 1 | Lookup comes from a fill passing through |
| lookup_addr | input | LINE_W | Line address to compare |
| lookup_match | output | 1 | An older entry already waits on the line |
| fill_valid | input | 1 | Memory response present |
| fill_id | input | IDW | Entry id carried by the response |
| fill_addr | output | LINE_W | Line address of entry `fill_id` |
| deq_valid | output | 1 | A ready entry is offered |
| deq_id | output | IDW | Id of the offered entry |
| deq_addr | output | LINE_W | Its line address |
| deq_wsel | output | PORTS*WSEL_W | Its word select |
| deq_ctag | output | PORTS*CTAG_W | Its core tag |
| deq_tid | output | PORTS*TID_W | Its thread ids |
| deq_pmask | output | PORTS | Its port mask |
| deq_ready | input | 1 | Consumer takes the offered entry |
| release_valid | input | 1 | Free an entry whose read hit |
| release_id | input | IDW | Entry to free |
| req_accept | input | 1 | A read request was accepted by the bank |
| almost_full | output | 1 | Occupancy at or above the threshold |

## Verification
On every cycle, the assertions check that an allocation never lands on a live entry and that it leaves that entry valid and not ready. They also check that a ready entry is always valid and that the dequeue offer is one ready entry. They check that dequeue and release free their entry and that a fill readies its own entry. Finally, they check that replay lookups never match and that the occupancy count never wraps below zero. The bench's scenarios are needed for the rest. They show that all waiters on a line wake together and that replay follows allocation order across reused ids. They also show that merged misses match while replays do not, and that the almost-full threshold tracks a mix of allocations, dequeues and releases.

// File: rtl/mshr_pkg.sv
package mshr_pkg;
  localparam int MAX_ENTRIES = 32;

  // index of the lowest set bit; 0 when the vector is empty
  function automatic logic [4:0] lowest_one(input logic [MAX_ENTRIES-1:0] v);
    logic [4:0] r;
    r = '0;
    for (int i = MAX_ENTRIES - 1; i >= 0; i--) begin
      if (v[i]) r = 5'(i);
    end
    return r;
  endfunction

  // occupancy threshold at which new requests must stop
  function automatic int afull_level(input int entries, input int margin);
    return entries - margin;
  endfunction
endpackage

// File: rtl/mshr_free_pick.sv
module mshr_free_pick #(
  parameter int ENTRIES = 4,
  parameter int IDW = 2
) (
  input  logic [ENTRIES-1:0] valid_q,
  output logic               free_any,
  output logic [IDW-1:0]     free_id
);
  import mshr_pkg::*;

  logic [ENTRIES-1:0] free_vec;

  assign free_vec = ~valid_q;
  assign free_any = |free_vec;
  assign free_id  = IDW'(lowest_one(MAX_ENTRIES'(free_vec)));
endmodule

// File: rtl/mshr_age_sel.sv
module mshr_age_sel #(
  parameter int ENTRIES = 4,
  parameter int IDW = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               alloc_fire,
  input  logic [IDW-1:0]     alloc_id,
  input  logic [ENTRIES-1:0] valid_q,
  input  logic [ENTRIES-1:0] ready_q,
  output logic               pick_valid,
  output logic [IDW-1:0]     pick_id
);
  import mshr_pkg::*;

  // older_q[i][j] set: entry j was allocated before entry i
  logic [ENTRIES-1:0] older_q [ENTRIES];
  logic [ENTRIES-1:0] pick_vec;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) older_q[i] <= '0;
    end else if (alloc_fire) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (IDW'(i) == alloc_id) older_q[i] <= valid_q;
        else                     older_q[i][alloc_id] <= 1'b0;
      end
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_pick
    assign pick_vec[g] = ready_q[g] && ((ready_q & older_q[g]) == '0);
  end

  assign pick_valid = |pick_vec;
  assign pick_id    = IDW'(lowest_one(MAX_ENTRIES'(pick_vec)));

  assert_pick_onehot_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(pick_vec));
  assert_pick_present_R5: assert property (@(posedge clk) disable iff (rst)
    (ready_q != '0) |-> pick_valid);
endmodule

// File: rtl/mshr_occ.sv
module mshr_occ #(
  parameter int ENTRIES = 4,
  parameter int AF_MARGIN = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic inc,
  input  logic dec_a,
  input  logic dec_b,
  output logic afull
);
  import mshr_pkg::*;

  localparam int CW = $clog2(ENTRIES + 2) + 1;
  localparam logic [CW-1:0] LEVEL = CW'(afull_level(ENTRIES, AF_MARGIN));

  logic [CW-1:0] count_q;
  logic [CW-1:0] count_d;

  assign count_d = count_q + CW'(inc) - CW'(dec_a) - CW'(dec_b);

  always_ff @(posedge clk) begin
    if (rst) count_q <= '0;
    else     count_q <= count_d;
  end

  assign afull = count_q >= LEVEL;

  assert_no_underflow_R7: assert property (@(posedge clk) disable iff (rst)
    (CW'(dec_a) + CW'(dec_b)) <= count_q + CW'(inc));
endmodule

// File: rtl/mshr_file.sv
module mshr_file #(
  parameter int ENTRIES = 4,
  parameter int LINE_W = 8,
  parameter int PORTS = 2,
  parameter int WSEL_W = 2,
  parameter int CTAG_W = 4,
  parameter int TID_W = 2,
  parameter int AF_MARGIN = 1,
  localparam int IDW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     alloc_valid,
  input  logic [LINE_W-1:0]        alloc_addr,
  input  logic [PORTS*WSEL_W-1:0]  alloc_wsel,
  input  logic [PORTS*CTAG_W-1:0]  alloc_ctag,
  input  logic [PORTS*TID_W-1:0]   alloc_tid,
  input  logic [PORTS-1:0]         alloc_pmask,
  output logic                     alloc_ready,
  output logic [IDW-1:0]           alloc_id,
  input  logic                     lookup_valid,
  input  logic                     lookup_replay,
  input  logic [LINE_W-1:0]        lookup_addr,
  output logic                     lookup_match,
  input  logic                     fill_valid,
  input  logic [IDW-1:0]           fill_id,
  output logic [LINE_W-1:0]        fill_addr,
  output logic                     deq_valid,
  output logic [IDW-1:0]           deq_id,
  output logic [LINE_W-1:0]        deq_addr,
  output logic [PORTS*WSEL_W-1:0]  deq_wsel,
  output logic [PORTS*CTAG_W-1:0]  deq_ctag,
  output logic [PORTS*TID_W-1:0]   deq_tid,
  output logic [PORTS-1:0]         deq_pmask,
  input  logic                     deq_ready,
  input  logic                     release_valid,
  input  logic [IDW-1:0]           release_id,
  input  logic                     req_accept,
  output logic                     almost_full
);
  localparam int META_W = PORTS * (WSEL_W + CTAG_W + TID_W + 1);

  logic [ENTRIES-1:0] valid_q, ready_q;
  logic [LINE_W-1:0]  addr_q [ENTRIES];
  logic [META_W-1:0]  meta_q [ENTRIES];

  // named internal events
  logic               alloc_fire;
  logic               deq_fire;
  logic [LINE_W-1:0]  fill_line;
  logic [ENTRIES-1:0] clear_vec;
  logic [ENTRIES-1:0] wake_vec;
  logic [ENTRIES-1:0] waiting_hit_vec;
  logic [META_W-1:0]  deq_meta;

  mshr_free_pick #(.ENTRIES(ENTRIES), .IDW(IDW)) u_free (
    .valid_q  (valid_q),
    .free_any (alloc_ready),
    .free_id  (alloc_id)
  );

  assign alloc_fire = alloc_valid && alloc_ready;

  mshr_age_sel #(.ENTRIES(ENTRIES), .IDW(IDW)) u_age (
    .clk        (clk),
    .rst        (rst),
    .alloc_fire (alloc_fire),
    .alloc_id   (alloc_id),
    .valid_q    (valid_q),
    .ready_q    (ready_q),
    .pick_valid (deq_valid),
    .pick_id    (deq_id)
  );

  assign deq_fire  = deq_valid && deq_ready;
  assign fill_line = addr_q[fill_id];
  assign fill_addr = fill_line;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
    assign clear_vec[g] = (deq_fire && deq_id == IDW'(g)) ||
                          (release_valid && release_id == IDW'(g));
    assign wake_vec[g]  = fill_valid && valid_q[g] && addr_q[g] == fill_line;
    assign waiting_hit_vec[g] = valid_q[g] && !ready_q[g] && addr_q[g] == lookup_addr;

    always_ff @(posedge clk) begin
      if (rst) begin
        valid_q[g] <= 1'b0;
        ready_q[g] <= 1'b0;
      end else if (clear_vec[g]) begin
        valid_q[g] <= 1'b0;
        ready_q[g] <= 1'b0;
      end else if (alloc_fire && alloc_id == IDW'(g)) begin
        valid_q[g] <= 1'b1;
        ready_q[g] <= 1'b0;
      end else if (wake_vec[g]) begin
        ready_q[g] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (alloc_fire && alloc_id == IDW'(g)) begin
        addr_q[g] <= alloc_addr;
        meta_q[g] <= {alloc_wsel, alloc_ctag, alloc_tid, alloc_pmask};
      end
    end

    assert_ready_needs_valid_R4: assert property (@(posedge clk) disable iff (rst)
      ready_q[g] |-> valid_q[g]);
  end

  assign lookup_match = lookup_valid && !lookup_replay && (|waiting_hit_vec);

  assign deq_meta = meta_q[deq_id];
  assign deq_addr = addr_q[deq_id];
  assign {deq_wsel, deq_ctag, deq_tid, deq_pmask} = deq_meta;

  mshr_occ #(.ENTRIES(ENTRIES), .AF_MARGIN(AF_MARGIN)) u_occ (
    .clk   (clk),
    .rst   (rst),
    .inc   (req_accept),
    .dec_a (deq_fire),
    .dec_b (release_valid),
    .afull (almost_full)
  );

  assert_alloc_free_R1: assert property (@(posedge clk) disable iff (rst)
    alloc_fire |-> !valid_q[alloc_id]);
  assert_alloc_sets_R1: assert property (@(posedge clk) disable iff (rst)
    alloc_fire |=> valid_q[$past(alloc_id)] && !ready_q[$past(alloc_id)]);
  assert_replay_nomatch_R2: assert property (@(posedge clk) disable iff (rst)
    lookup_replay |-> !lookup_match);
  assert_fill_wake_R4: assert property (@(posedge clk) disable iff (rst)
    (fill_valid && valid_q[fill_id] && !clear_vec[fill_id]) |=> ready_q[$past(fill_id)]);
  assert_deq_offer_R5: assert property (@(posedge clk) disable iff (rst)
    deq_valid |-> valid_q[deq_id] && ready_q[deq_id]);
  assert_deq_frees_R5: assert property (@(posedge clk) disable iff (rst)
    deq_fire |=> !valid_q[$past(deq_id)]);
  assert_release_frees_R6: assert property (@(posedge clk) disable iff (rst)
    (release_valid && valid_q[release_id]) |=> !valid_q[$past(release_id)]);
endmodule

// File: tb/tb_mshr_file.sv
`timescale 1ns/1ps
module tb_mshr_file;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic        alloc_valid, lookup_valid, lookup_replay, fill_valid;
  logic        deq_ready, release_valid, req_accept;
  logic [7:0]  alloc_addr, lookup_addr;
  logic [3:0]  alloc_wsel, alloc_tid;
  logic [7:0]  alloc_ctag;
  logic [1:0]  alloc_pmask, fill_id, release_id;
  logic        alloc_ready, lookup_match, deq_valid, almost_full;
  logic [1:0]  alloc_id, deq_id, deq_pmask;
  logic [7:0]  fill_addr, deq_addr, deq_ctag;
  logic [3:0]  deq_wsel, deq_tid;

  mshr_file dut (
    .clk(clk), .rst(rst),
    .alloc_valid(alloc_valid), .alloc_addr(alloc_addr), .alloc_wsel(alloc_wsel),
    .alloc_ctag(alloc_ctag), .alloc_tid(alloc_tid), .alloc_pmask(alloc_pmask),
    .alloc_ready(alloc_ready), .alloc_id(alloc_id),
    .lookup_valid(lookup_valid), .lookup_replay(lookup_replay),
    .lookup_addr(lookup_addr), .lookup_match(lookup_match),
    .fill_valid(fill_valid), .fill_id(fill_id), .fill_addr(fill_addr),
    .deq_valid(deq_valid), .deq_id(deq_id), .deq_addr(deq_addr),
    .deq_wsel(deq_wsel), .deq_ctag(deq_ctag), .deq_tid(deq_tid),
    .deq_pmask(deq_pmask), .deq_ready(deq_ready),
    .release_valid(release_valid), .release_id(release_id),
    .req_accept(req_accept), .almost_full(almost_full)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // reference model
  bit         mv [N];
  bit         mr [N];
  logic [7:0] ma [N];
  logic [17:0] mm [N];
  int         mseq [N];
  int         seqctr = 0;
  int         cnt = 0;
  int         exp_pick;
  int         exp_free;

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic int low_free();
    for (int i = 0; i < N; i++) if (!mv[i]) return i;
    return -1;
  endfunction

  function automatic bit waits_on(input logic [7:0] a);
    for (int i = 0; i < N; i++) if (mv[i] && !mr[i] && ma[i] == a) return 1'b1;
    return 1'b0;
  endfunction

  function automatic int oldest_ready();
    int best = -1;
    for (int i = 0; i < N; i++)
      if (mr[i] && (best < 0 || mseq[i] < mseq[best])) best = i;
    return best;
  endfunction

  task automatic idle_inputs();
    alloc_valid = 0; lookup_valid = 0; lookup_replay = 0; fill_valid = 0;
    deq_ready = 0; release_valid = 0; req_accept = 0;
    alloc_addr = 0; lookup_addr = 0; alloc_wsel = 0; alloc_tid = 0;
    alloc_ctag = 0; alloc_pmask = 0; fill_id = 0; release_id = 0;
  endtask

  // apply inputs at the falling edge and compare combinational outputs
  task automatic drive(input bit av, input logic [7:0] aa, input logic [17:0] am,
                       input bit lv, input bit lr, input logic [7:0] la,
                       input bit fv, input int fid, input bit rv, input int rid,
                       input bit dr);
    @(negedge clk);
    alloc_valid = av; alloc_addr = aa;
    {alloc_wsel, alloc_ctag, alloc_tid, alloc_pmask} = am;
    lookup_valid = lv; lookup_replay = lr; lookup_addr = la;
    fill_valid = fv; fill_id = 2'(fid);
    release_valid = rv; release_id = 2'(rid);
    deq_ready = dr; req_accept = av;
    #1;
    exp_free = low_free();
    exp_pick = oldest_ready();
    chk(alloc_ready == (exp_free >= 0), "R1 alloc_ready", alloc_ready, exp_free >= 0);
    if (exp_free >= 0) chk(alloc_id == 2'(exp_free), "R1 alloc_id", alloc_id, exp_free);
    chk(lookup_match == (lv && !lr && waits_on(la)), "R3 lookup_match",
        lookup_match, lv && !lr && waits_on(la));
    if (fv) chk(fill_addr == ma[fid], "R4 fill_addr", fill_addr, ma[fid]);
    chk(deq_valid == (exp_pick >= 0), "R5 deq_valid", deq_valid, exp_pick >= 0);
    if (exp_pick >= 0) begin
      chk(deq_id == 2'(exp_pick), "R5 deq_id", deq_id, exp_pick);
      chk(deq_addr == ma[exp_pick], "R5 deq_addr", deq_addr, ma[exp_pick]);
      chk({deq_wsel, deq_ctag, deq_tid, deq_pmask} == mm[exp_pick], "R5 deq_meta",
          {deq_wsel, deq_ctag, deq_tid, deq_pmask}, mm[exp_pick]);
    end
    chk(almost_full == (cnt >= N - 1), "R7 almost_full", almost_full, cnt >= N - 1);
  endtask

  // advance the model across the rising edge
  task automatic commit();
    logic [7:0] fl;
    bit dfire;
    @(posedge clk);
    fl = ma[fill_id];
    dfire = deq_ready && exp_pick >= 0;
    for (int i = 0; i < N; i++) begin
      if ((dfire && i == exp_pick) || (release_valid && i == int'(release_id))) begin
        mv[i] = 0; mr[i] = 0;
      end else if (alloc_valid && exp_free == i) begin
        mv[i] = 1; mr[i] = 0; ma[i] = alloc_addr;
        mm[i] = {alloc_wsel, alloc_ctag, alloc_tid, alloc_pmask};
        mseq[i] = seqctr++;
      end else if (fill_valid && mv[i] && ma[i] == fl) begin
        mr[i] = 1;
      end
    end
    cnt = cnt + int'(alloc_valid) - int'(dfire) - int'(release_valid);
  endtask

  task automatic step(input bit av, input logic [7:0] aa, input logic [17:0] am,
                      input bit lv, input bit lr, input logic [7:0] la,
                      input bit fv, input int fid, input bit rv, input int rid,
                      input bit dr);
    drive(av, aa, am, lv, lr, la, fv, fid, rv, rid, dr);
    commit();
  endtask

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    idle_inputs();
    for (int i = 0; i < N; i++) begin mv[i] = 0; mr[i] = 0; ma[i] = 0; mm[i] = 0; mseq[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    #1;
    // R8: reset state
    chk(alloc_ready == 1'b1, "R8 alloc_ready", alloc_ready, 1);
    chk(alloc_id == 2'd0, "R8 alloc_id", alloc_id, 0);
    chk(deq_valid == 1'b0, "R8 deq_valid", deq_valid, 0);
    chk(lookup_match == 1'b0, "R8 lookup_match", lookup_match, 0);
    chk(almost_full == 1'b0, "R8 almost_full", almost_full, 0);

    // R3: first miss to a line has no older waiter, the second merges
    drive(1, 8'h40, 18'h0_1111, 1, 0, 8'h40, 0, 0, 0, 0, 0);
    chk(lookup_match == 1'b0, "R3 first miss", lookup_match, 0);
    commit();
    drive(1, 8'h40, 18'h2_2222, 1, 0, 8'h40, 0, 0, 0, 0, 0);
    chk(lookup_match == 1'b1, "R3 merged miss", lookup_match, 1);
    chk(alloc_id == 2'd1, "R1 second id", alloc_id, 1);
    commit();
    step(1, 8'h55, 18'h3_3333, 1, 0, 8'h55, 0, 0, 0, 0, 0);
    drive(1, 8'h40, 18'h0_4444, 0, 0, 0, 0, 0, 0, 0, 0);
    chk(almost_full == 1'b1, "R7 threshold reached", almost_full, 1);
    commit();
    // R1 full, R2 replay lookup never matches and does not allocate
    drive(0, 0, 0, 1, 1, 8'h40, 0, 0, 0, 0, 0);
    chk(alloc_ready == 1'b0, "R1 all busy", alloc_ready, 0);
    chk(lookup_match == 1'b0, "R2 replay lookup", lookup_match, 0);
    commit();
    // R6: release the hit on 0x55 (id 2), then it is reused first
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, 2, 0);
    drive(0, 0, 0, 0, 0, 0, 1, 1, 0, 0, 0);
    chk(alloc_ready == 1'b1 && alloc_id == 2'd2, "R6 id reused", alloc_id, 2);
    chk(fill_addr == 8'h40, "R4 fill line", fill_addr, 8'h40);
    commit();
    // R4/R5: all three waiters on 0x40 woke; replay oldest first 0,1,3
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    chk(deq_valid && deq_id == 2'd0, "R5 oldest first", deq_id, 0);
    commit();
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    chk(deq_id == 2'd1, "R5 second", deq_id, 1);
    commit();
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    chk(deq_id == 2'd3 && deq_ctag == 8'h11, "R4 all waiters woke", deq_id, 3);
    commit();
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    chk(deq_valid == 1'b0 && almost_full == 1'b0, "R7 drained", deq_valid, 0);
    commit();

    // random traffic against the model (R1..R7)
    for (int t = 0; t < 4000; t++) begin
      int lf, fid, rid;
      bit av, fv, rv;
      lf = low_free();
      av = (lf >= 0) && ($urandom % 3 != 0);
      fv = 0; fid = 0; rv = 0; rid = 0;
      if ($urandom % 4 == 0) begin
        int c = $urandom % N;
        if (mv[c]) begin fv = 1; fid = c; end
      end
      if ($urandom % 4 == 0) begin
        int c = $urandom % N;
        if (mv[c] && !mr[c]) begin rv = 1; rid = c; end
      end
      step(av, 8'h10 + 8'($urandom % 4), 18'($urandom),
           $urandom % 2 == 0, $urandom % 4 == 0, 8'h10 + 8'($urandom % 4),
           fv, fid, rv, rid, $urandom % 4 != 0);
    end

    idle_inputs();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule